// File: doc/BRIEF.md
# Packed Table Entry Parser

This block takes one entry fetched from an instruction lookup table and splits it into the instructions packed inside it. An entry is either 32 or 64 bits wide. A single input flag says which width applies. The parser works out each instruction's length from its low bits. It then checks that the lengths form one of the allowed combinations, and that every leftover 16-bit parcel holds the compressed no-op pattern 16'h0001. It also rejects any instruction that computes an address relative to the program counter.

For each of up to two instruction slots it reports the instruction bits (right-aligned in 48 bits), a length code and the count of instructions. It also raises one illegal flag for the entry as a whole. The logic is combinational. A parameter places a register stage on the outputs. A downstream execution stage consumes the slots in order, or turns the illegal flag into an illegal-instruction exception.

Top module: `ilut_entry_parser`

## Requirements
- R1: A 16-bit parcel is classed as 16-bit when bits[1:0]!=11, 48-bit when bits[5:0]==011111, 32-bit when bits[1:0]==11 and bits[4:2]!=111, and unrecognised otherwise. Length codes on the outputs are 00 none, 01 16-bit, 10 32-bit, 11 48-bit. In a 32-bit entry whose first parcel is 32-bit class, slot 0 carries bits[31:0], its length code is 10, and the count is 1.
- R2: In a 32-bit entry whose first parcel is 16-bit class, slot 0 carries bits[15:0] and slot 1 carries bits[31:16], and the count is 2. This holds only when bits[31:16] is itself 16-bit class; otherwise the entry is illegal.
- R3: In a 32-bit entry, a first parcel of 48-bit or unrecognised class is illegal. In that mode, input bits[63:32] have no effect on any output.
- R4: In a 64-bit entry with a 16-bit first parcel, a 32-bit second instruction at bits[47:16] is accepted when bits[63:48]==16'h0001. A 48-bit second instruction at bits[63:16] is also accepted.
- R5: In a 64-bit entry with a 32-bit first instruction, a 16-bit second instruction at bits[47:32] is accepted when bits[63:48]==16'h0001. A 32-bit second instruction at bits[63:32] is also accepted.
- R6: In a 64-bit entry whose first parcel is 48-bit class, a single instruction at bits[47:0] is accepted with count 1 when bits[63:48]==16'h0001.
- R7: A leftover 16-bit parcel other than 16'h0001 makes the entry illegal.
- R8: Any other 64-bit combination is illegal. This covers 16+16, 32+48, and an unrecognised first or second parcel.
- R9: A 32-bit instruction whose opcode bits[6:0] is 0010111, 1100011, 1101111 or 1100111 makes the entry illegal.
- R10: A 16-bit instruction makes the entry illegal in two cases. The first is quadrant 01 with bits[15:13] in {001,101,110,111}. The second is quadrant 10 with bits[15:13]==100, bits[6:2]==0 and bits[11:7]!=0. Other 16-bit instructions, such as register moves and breakpoints, are accepted.
- R11: When the entry is illegal, the illegal output is 1, the count is 0, both length codes are 00, and both slot buses are zero. When the entry is legal, the illegal output is 0 and unused slot fields are zero.
- R12: With the output register enabled (the default), outputs follow the inputs one clock edge later, and they are all zero while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| entry_i | input | 64 | Fetched table entry; only bits[31:0] used in 32-bit mode |
| wide_i | input | 1 | 1 = 64-bit entry, 0 = 32-bit entry |
| slot0_bits_o | output | 48 | First instruction, right-aligned |
| slot0_len_o | output | 2 | Length code of first instruction |
| slot1_bits_o | output | 48 | Second instruction, right-aligned |
| slot1_len_o | output | 2 | Length code of second instruction |
| count_o | output | 2 | Number of instructions in the entry (0, 1 or 2) |
| illegal_o | output | 1 | Entry violates packing, padding or opcode rules |

## Verification
Directed entries cover each allowed combination in both widths. Each is set beside a near-miss that differs in one point: a second-parcel length that does not fit, a padding parcel one bit off, or a compressed register move beside the jump form that shares its quadrant and funct3. Seeded random entries are built by choosing a length class for each parcel. This covers the combinations the parser must tell apart, and lets program-counter-relative opcodes and bad padding appear by chance. A fully random pattern exercises unrecognised length classes. A value placed in the unused upper half of a 32-bit entry shows that half is ignored. A mid-cycle sample shows the registered outputs wait for the clock edge.

// File: rtl/ilut_pkg.sv
package ilut_pkg;

    localparam int PARCEL_W = 16;
    localparam int SLOT_W   = 48;
    localparam int ENTRY_W  = 64;
    localparam int NPARCEL  = 3;
    localparam logic [PARCEL_W-1:0] PAD_PARCEL = 16'h0001;

    typedef enum logic [1:0] {
        LEN_NONE = 2'b00,
        LEN_16   = 2'b01,
        LEN_32   = 2'b10,
        LEN_48   = 2'b11
    } ilen_e;

    typedef struct packed {
        logic [SLOT_W-1:0] bits0;
        ilen_e             len0;
        logic [SLOT_W-1:0] bits1;
        ilen_e             len1;
        logic [1:0]        count;
        logic              illegal;
    } parse_t;

endpackage

// File: rtl/ilut_len_class.sv
module ilut_len_class
    import ilut_pkg::*;
(
    input  logic [PARCEL_W-1:0] parcel_i,
    output ilen_e               len_o
);
    always_comb begin
        if (parcel_i[1:0] != 2'b11)
            len_o = LEN_16;
        else if (parcel_i[5:0] == 6'b011111)
            len_o = LEN_48;
        else if (parcel_i[4:2] != 3'b111)
            len_o = LEN_32;
        else
            len_o = LEN_NONE;
    end
endmodule

// File: rtl/ilut_pcrel_detect.sv
module ilut_pcrel_detect
    import ilut_pkg::*;
(
    input  logic [SLOT_W-1:0] insn_i,
    input  ilen_e             len_i,
    output logic              pcrel_o
);
    logic [6:0] opc;
    logic [1:0] quad;
    logic [2:0] f3;
    logic       cq1_hit;
    logic       cq2_hit;
    logic       wide_hit;

    always_comb begin
        opc      = insn_i[6:0];
        quad     = insn_i[1:0];
        f3       = insn_i[15:13];
        cq1_hit  = (quad == 2'b01) &&
                   ((f3 == 3'b001) || (f3 == 3'b101) || (f3 == 3'b110) || (f3 == 3'b111));
        cq2_hit  = (quad == 2'b10) && (f3 == 3'b100) &&
                   (insn_i[6:2] == 5'd0) && (insn_i[11:7] != 5'd0);
        wide_hit = (opc == 7'b0010111) || (opc == 7'b1100011) ||
                   (opc == 7'b1101111) || (opc == 7'b1100111);
        case (len_i)
            LEN_16:  pcrel_o = cq1_hit || cq2_hit;
            LEN_32:  pcrel_o = wide_hit;
            default: pcrel_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ilut_entry_parser.sv
module ilut_entry_parser
    import ilut_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic              wide_i,
    output logic [SLOT_W-1:0] slot0_bits_o,
    output logic [1:0]        slot0_len_o,
    output logic [SLOT_W-1:0] slot1_bits_o,
    output logic [1:0]        slot1_len_o,
    output logic [1:0]        count_o,
    output logic              illegal_o
);
    localparam int NSLOT = 2;

    ilen_e  pcls [NPARCEL];
    parse_t cand;
    logic   fit_ok;
    logic   pad_ok;
    logic [NSLOT-1:0] pcrel;
    parse_t out_d;
    parse_t out_q;

    for (genvar k = 0; k < NPARCEL; k++) begin : g_cls
        ilut_len_class u_cls (
            .parcel_i (entry_i[k*PARCEL_W +: PARCEL_W]),
            .len_o    (pcls[k])
        );
    end

    // Split the entry according to the parcel classes.
    always_comb begin
        cand   = '0;
        fit_ok = 1'b0;
        pad_ok = 1'b1;
        if (!wide_i) begin
            if (pcls[0] == LEN_32) begin
                cand.bits0 = {16'h0, entry_i[31:0]};
                cand.len0  = LEN_32;
                cand.count = 2'd1;
                fit_ok     = 1'b1;
            end else if (pcls[0] == LEN_16 && pcls[1] == LEN_16) begin
                cand.bits0 = {32'h0, entry_i[15:0]};
                cand.len0  = LEN_16;
                cand.bits1 = {32'h0, entry_i[31:16]};
                cand.len1  = LEN_16;
                cand.count = 2'd2;
                fit_ok     = 1'b1;
            end
        end else begin
            case (pcls[0])
                LEN_16: begin
                    cand.bits0 = {32'h0, entry_i[15:0]};
                    cand.len0  = LEN_16;
                    if (pcls[1] == LEN_32) begin
                        cand.bits1 = {16'h0, entry_i[47:16]};
                        cand.len1  = LEN_32;
                        pad_ok     = (entry_i[63:48] == PAD_PARCEL);
                        fit_ok     = 1'b1;
                    end else if (pcls[1] == LEN_48) begin
                        cand.bits1 = entry_i[63:16];
                        cand.len1  = LEN_48;
                        fit_ok     = 1'b1;
                    end
                    cand.count = 2'd2;
                end
                LEN_32: begin
                    cand.bits0 = {16'h0, entry_i[31:0]};
                    cand.len0  = LEN_32;
                    if (pcls[2] == LEN_16) begin
                        cand.bits1 = {32'h0, entry_i[47:32]};
                        cand.len1  = LEN_16;
                        pad_ok     = (entry_i[63:48] == PAD_PARCEL);
                        fit_ok     = 1'b1;
                    end else if (pcls[2] == LEN_32) begin
                        cand.bits1 = {16'h0, entry_i[63:32]};
                        cand.len1  = LEN_32;
                        fit_ok     = 1'b1;
                    end
                    cand.count = 2'd2;
                end
                LEN_48: begin
                    cand.bits0 = entry_i[47:0];
                    cand.len0  = LEN_48;
                    cand.count = 2'd1;
                    pad_ok     = (entry_i[63:48] == PAD_PARCEL);
                    fit_ok     = 1'b1;
                end
                default: fit_ok = 1'b0;
            endcase
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_pcrel
        ilut_pcrel_detect u_pcrel (
            .insn_i  ((s == 0) ? cand.bits0 : cand.bits1),
            .len_i   ((s == 0) ? cand.len0  : cand.len1),
            .pcrel_o (pcrel[s])
        );
    end

    // Next-value process.
    always_comb begin
        out_d = cand;
        if (!fit_ok || !pad_ok || (|pcrel)) begin
            out_d         = '0;
            out_d.illegal = 1'b1;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        always_comb out_q = out_d;
    end

    assign slot0_bits_o = out_q.bits0;
    assign slot0_len_o  = out_q.len0;
    assign slot1_bits_o = out_q.bits1;
    assign slot1_len_o  = out_q.len1;
    assign count_o      = out_q.count;
    assign illegal_o    = out_q.illegal;

    // Assertions
    a_r11_illegal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        out_d.illegal |-> (out_d.count == 2'd0 && out_d.len0 == LEN_NONE &&
                           out_d.len1 == LEN_NONE && out_d.bits0 == '0 && out_d.bits1 == '0));

    a_r2_count_matches_lens: assert property (@(posedge clk) disable iff (!rst_n)
        !out_d.illegal |-> (out_d.len0 != LEN_NONE) &&
                           ((out_d.count == 2'd2) == (out_d.len1 != LEN_NONE)));

    a_r9_pcrel_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (|pcrel) |-> out_d.illegal);

    a_r3_narrow_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_i && !out_d.illegal) |->
            (out_d.len0 == LEN_32 && out_d.count == 2'd1) ||
            (out_d.len0 == LEN_16 && out_d.len1 == LEN_16));

    a_r8_wide_no_short_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && !out_d.illegal) |->
            !(out_d.len0 == LEN_16 && out_d.len1 == LEN_16) && out_d.len1 != LEN_48 ||
            (out_d.len0 == LEN_16 && out_d.len1 == LEN_48));

    a_r12_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && $past(rst_n)) |-> (out_q == $past(out_d)));

endmodule

// File: tb/test_ilut_entry_parser.sv
module test_ilut_entry_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] entry = '0;
    logic        wide = 1'b0;
    logic [47:0] s0b, s1b;
    logic [1:0]  s0l, s1l, cnt;
    logic        ill;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ilut_entry_parser i_ilut_entry_parser (
        .clk(clk), .rst_n(rst_n), .entry_i(entry), .wide_i(wide),
        .slot0_bits_o(s0b), .slot0_len_o(s0l), .slot1_bits_o(s1b),
        .slot1_len_o(s1l), .count_o(cnt), .illegal_o(ill)
    );

    function automatic logic [1:0] cls(input logic [15:0] p);
        if (p[1:0] != 2'b11) return 2'b01;
        if (p[5:0] == 6'b011111) return 2'b11;
        if (p[4:2] != 3'b111) return 2'b10;
        return 2'b00;
    endfunction

    function automatic bit is_pcrel(input logic [47:0] b, input logic [1:0] l);
        if (l == 2'b10)
            return b[6:0] inside {7'b0010111, 7'b1100011, 7'b1101111, 7'b1100111};
        if (l == 2'b01) begin
            if (b[1:0] == 2'b01 && b[15:13] inside {3'b001, 3'b101, 3'b110, 3'b111}) return 1;
            if (b[1:0] == 2'b10 && b[15:13] == 3'b100 && b[6:2] == 0 && b[11:7] != 0) return 1;
        end
        return 0;
    endfunction

    // Expected {bits0,len0,bits1,len1,count,illegal}
    function automatic logic [102:0] model(input logic [63:0] e, input logic w);
        logic [47:0] b0 = '0, b1 = '0;
        logic [1:0]  l0 = 0, l1 = 0, c = 0;
        bit ok = 0;
        logic [1:0] k0 = cls(e[15:0]);
        if (!w) begin
            if (k0 == 2'b10) begin b0 = {16'h0, e[31:0]}; l0 = 2'b10; c = 1; ok = 1; end
            else if (k0 == 2'b01 && cls(e[31:16]) == 2'b01) begin
                b0 = {32'h0, e[15:0]}; l0 = 1; b1 = {32'h0, e[31:16]}; l1 = 1; c = 2; ok = 1;
            end
        end else if (k0 == 2'b01) begin
            b0 = {32'h0, e[15:0]}; l0 = 1; c = 2;
            if (cls(e[31:16]) == 2'b10) begin b1 = {16'h0, e[47:16]}; l1 = 2; ok = (e[63:48] == 16'h0001); end
            else if (cls(e[31:16]) == 2'b11) begin b1 = e[63:16]; l1 = 3; ok = 1; end
        end else if (k0 == 2'b10) begin
            b0 = {16'h0, e[31:0]}; l0 = 2; c = 2;
            if (cls(e[47:32]) == 2'b01) begin b1 = {32'h0, e[47:32]}; l1 = 1; ok = (e[63:48] == 16'h0001); end
            else if (cls(e[47:32]) == 2'b10) begin b1 = {16'h0, e[63:32]}; l1 = 2; ok = 1; end
        end else if (k0 == 2'b11) begin
            b0 = e[47:0]; l0 = 3; c = 1; ok = (e[63:48] == 16'h0001);
        end
        if (ok && (is_pcrel(b0, l0) || is_pcrel(b1, l1))) ok = 0;
        if (!ok) return {102'h0, 1'b1};
        return {b0, l0, b1, l1, c, 1'b0};
    endfunction

    function automatic logic [102:0] actual();
        return {s0b, s0l, s1b, s1l, cnt, ill};
    endfunction

    task automatic chk(input string tag, input logic [102:0] act, input logic [102:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] e, input logic w, input logic exp_ill, input string tag);
        logic [102:0] exp = model(e, w);
        @(negedge clk);
        entry = e; wide = w;
        @(negedge clk);
        chk(tag, actual(), exp);
        checks++;
        if (ill !== exp_ill) begin
            fails++;
            $display("FAIL %s illegal actual=%b expected=%b", tag, ill, exp_ill);
        end
    endtask

    function automatic logic [15:0] gen16();
        logic [15:0] r = 16'($urandom);
        r[1:0] = 2'($urandom % 3);
        return r;
    endfunction
    function automatic logic [31:0] gen32();
        logic [31:0] r = $urandom;
        r[1:0] = 2'b11; r[4:2] = 3'($urandom % 7);
        return r;
    endfunction
    function automatic logic [47:0] gen48();
        logic [47:0] r = {16'($urandom), $urandom};
        r[5:0] = 6'b011111;
        return r;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset zero", actual(), 103'h0);
        entry = {32'h0, 32'h00A00093};
        @(negedge clk);
        chk("R12 reset holds", actual(), 103'h0);
        rst_n = 1'b1;

        run({32'h0, 32'h00A00093}, 0, 0, "R1 narrow single 32");
        run({32'hDEADBEEF, 32'h00A00093}, 0, 0, "R3 upper half ignored");
        run({32'h0, 32'h4505_0001}, 0, 0, "R2 narrow 16+16");
        run({32'h0, 32'h0093_0001}, 0, 1, "R2 upper half not 16");
        run({32'h0, 32'h0000_001F}, 0, 1, "R3 narrow 48 first");
        run({32'h0, 32'h0000_007F}, 0, 1, "R3 narrow unrecognised");
        run({16'h0001, 32'h00A00093, 16'h4505}, 1, 0, "R4 16+32");
        run({48'hABCD_1234_001F, 16'h4505}, 1, 0, "R4 16+48");
        run({16'h0001, 16'h4505, 32'h00A00093}, 1, 0, "R5 32+16");
        run({32'h00B00113, 32'h00A00093}, 1, 0, "R5 32+32");
        run({16'h0001, 48'h0000_1111_001F}, 1, 0, "R6 single 48");
        run({16'h0002, 48'h0000_1111_001F}, 1, 1, "R7 bad pad after 48");
        run({16'h4505, 16'h4505, 32'h00A00093}, 1, 1, "R7 bad pad after 32+16");
        run({16'h0003, 32'h00A00093, 16'h4505}, 1, 1, "R7 bad pad after 16+32");
        run({32'h0000_0001, 16'h4505, 16'h4505}, 1, 1, "R8 wide 16+16");
        run({16'h0001, 16'h001F, 32'h00A00093}, 1, 1, "R8 wide 32+48");
        run({48'h0, 16'h007F}, 1, 1, "R8 unrecognised first");
        run({16'h0001, 16'h007F, 32'h00A00093}, 1, 1, "R8 unrecognised second");
        run({32'h0, 32'h00000097}, 0, 1, "R9 auipc");
        run({32'h0, 32'h0000006F}, 0, 1, "R9 jal");
        run({32'h0, 32'h00008067}, 0, 1, "R9 jalr");
        run({32'h00000063, 32'h00A00093}, 1, 1, "R9 branch second slot");
        run({32'h0, 32'h0001_A001}, 0, 1, "R10 c.j");
        run({32'h0, 32'hC001_0001}, 0, 1, "R10 c.beqz");
        run({32'h0, 32'h0001_2001}, 0, 1, "R10 c.jal");
        run({32'h0, 32'h0001_8082}, 0, 1, "R10 c.jr");
        run({32'h0, 32'h0001_808A}, 0, 0, "R10 c.mv accepted");
        run({32'h0, 32'h9002_0001}, 0, 0, "R10 c.ebreak accepted");
        run({16'h0001, 32'h00A00093, 16'hE001}, 1, 1, "R11 c.bnez clears outputs");

        // R12: output waits for the edge
        @(negedge clk);
        entry = {32'h0, 32'h00B00113}; wide = 0;
        #1;
        chk("R12 before edge", actual(), model({16'h0001, 32'h00A00093, 16'hE001}, 1));
        @(negedge clk);
        chk("R12 after edge", actual(), model({32'h0, 32'h00B00113}, 0));

        for (int n = 0; n < 600; n++) begin
            logic [63:0] e;
            logic w = 1;
            int pat = $urandom % 8;
            logic [15:0] pad = ($urandom % 8 == 0) ? 16'($urandom) : 16'h0001;
            case (pat)
                0: begin e = {$urandom, gen32()}; w = 0; end
                1: begin e = {$urandom, gen16(), gen16()}; w = 0; end
                2: e = {pad, gen32(), gen16()};
                3: e = {gen48(), gen16()};
                4: e = {pad, gen16(), gen32()};
                5: e = {gen32(), gen32()};
                6: e = {pad, gen48()};
                default: begin e = {$urandom, $urandom}; w = 1'($urandom); end
            endcase
            @(negedge clk);
            entry = e; wide = w;
            @(negedge clk);
            chk($sformatf("R1-class random pattern %0d (R4 R5 R6 R7 R9 R10)", pat), actual(), model(e, w));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule